// File: doc/BRIEF.md
# UART Baud Tick Generator with Prescaler and 13x Oversampling

This block derives the sampling strobes of a serial port from a fast reference clock. The clock is first slowed by a 4-bit prescaler, whose intended output is near 12 MHz. A 10-bit baud divisor follows. Every divisor wrap produces one oversample tick, and thirteen oversample ticks make one bit time. The same settings cover rates from 900 to 921600 baud. The shifters and FIFOs of the port consume the two tick outputs.

Both settings are written through one word-wide write port into a single divisor word. A new word is not applied at once. It waits until the running prescaler completes its current count. During that wait a busy flag is raised, and software polls the flag before it writes again. Writes made while the flag is set are dropped. The word that is in effect can be read back at any time.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both fields are 0, which means divide by 1. busy is 0 and divValue reads 0. ovsTick is high on every cycle, and bitTick pulses once every 13 cycles.
- R2: In a written word, bits 19:16 carry (prescale - 1) and bits 9:0 carry (baud divisor - 1). All other bits are ignored. divValue returns the active fields at the same positions, with every other bit at zero.
- R3: With active fields p and d, ovsTick is a one-cycle pulse that repeats every (p+1)*(d+1) clock cycles.
- R4: bitTick is a one-cycle pulse. It occurs only together with ovsTick, on every 13th oversample tick, so its period is 13*(p+1)*(d+1) cycles.
- R5: A write made while busy is 0 is accepted, and busy reads 1 from the next cycle.
- R6: A pending word takes effect at the first wrap of the old prescaler count. busy falls within (old p + 1) cycles of the write, and it falls in the same cycle that the new fields appear on divValue.
- R7: A write made while busy is 1 has no effect. The earlier pending word is the one that takes effect.
- R8: Applying a new word restarts all counters. The first ovsTick comes (p+1)*(d+1) cycles after busy falls, and the first bitTick comes 13 times that many cycles after busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the divisor word |
| wrData | input | 32 | Divisor word to be written |
| busy | output | 1 | High while a written word has not yet been applied |
| divValue | output | 32 | Active prescale and divisor fields, read back |
| ovsTick | output | 1 | One-cycle oversample strobe |
| bitTick | output | 1 | One-cycle strobe, one per bit time |

## Verification
Most faults in this block show up as wrong tick timing. A prescale or divisor counter that wraps one step early or late changes the oversample period, and the error is visible within one period. An oversample counter that wraps at the wrong point stretches the bit period. That fault is only visible after 13 oversample ticks, which is why the bench measures bitTick periods and not only ovsTick periods. Faults in the update path show up in two ways. A lost restart moves the first tick after busy falls. A pending word that an ignored write has overwritten appears on divValue as soon as busy drops.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int REG_W   = 32;
  localparam int PRE_W   = 4;
  localparam int DIV_W   = 10;
  localparam int PRE_LSB = 16;
  localparam int DIV_LSB = 0;
  localparam int OVS     = 13;

  typedef struct packed {
    logic load;
  } baudStrobe_t;
endpackage

// File: rtl/uart_baud_ctrl.sv
module uart_baud_ctrl
  import uart_baud_pkg::*;
#(
  parameter int RegW   = REG_W,
  parameter int PreW   = PRE_W,
  parameter int DivW   = DIV_W,
  parameter int PreLsb = PRE_LSB,
  parameter int DivLsb = DIV_LSB
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [RegW-1:0] wrData,
  input  logic            preWrap,
  output logic [PreW-1:0] activePre,
  output logic [DivW-1:0] activeDiv,
  output logic            busy,
  output baudStrobe_t     strobe
);
  logic [PreW-1:0] pendPre;
  logic [DivW-1:0] pendDiv;
  logic            accept;

  assign accept      = wrEn && !busy;
  assign strobe.load = busy && preWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPre   <= '0;
      pendDiv   <= '0;
      activePre <= '0;
      activeDiv <= '0;
      busy      <= 1'b0;
    end else if (accept) begin
      pendPre <= wrData[PreLsb +: PreW];
      pendDiv <= wrData[DivLsb +: DivW];
      busy    <= 1'b1;
    end else if (strobe.load) begin
      activePre <= pendPre;
      activeDiv <= pendDiv;
      busy      <= 1'b0;
    end
  end

  // R5: an idle write raises busy on the next cycle
  a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> busy);

  // R6: busy only drops on a prescaler wrap
  a_r6_fall_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(preWrap));

  // R7: active fields change only through a load
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(activePre) && $stable(activeDiv)));
endmodule

// File: rtl/uart_baud_datapath.sv
module uart_baud_datapath
  import uart_baud_pkg::*;
#(
  parameter int PreW = PRE_W,
  parameter int DivW = DIV_W,
  parameter int Ovs  = OVS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PreW-1:0] activePre,
  input  logic [DivW-1:0] activeDiv,
  input  baudStrobe_t     strobe,
  output logic            preWrap,
  output logic            ovsTick,
  output logic            bitTick
);
  localparam int OvsW = (Ovs > 1) ? $clog2(Ovs) : 1;
  localparam logic [OvsW-1:0] OvsLast = OvsW'(Ovs - 1);

  logic [PreW-1:0] preCnt;
  logic [DivW-1:0] divCnt;
  logic [OvsW-1:0] ovsCnt;
  logic            divWrap;

  assign preWrap = (preCnt == activePre);
  assign divWrap = (divCnt == activeDiv);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.load) begin
      preCnt  <= '0;
      divCnt  <= '0;
      ovsCnt  <= '0;
      ovsTick <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      ovsTick <= 1'b0;
      bitTick <= 1'b0;
      if (preWrap) begin
        preCnt <= '0;
        if (divWrap) begin
          divCnt  <= '0;
          ovsTick <= 1'b1;
          if (ovsCnt == OvsLast) begin
            ovsCnt  <= '0;
            bitTick <= 1'b1;
          end else begin
            ovsCnt <= ovsCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R4: a bit tick always coincides with an oversample tick
  a_r4_bit_on_ovs: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> ovsTick);

  // R3: the prescale count never passes its limit
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= activePre);

  // R3: pulses are one cycle wide unless the total division is 1
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (ovsTick && !(activePre == '0 && activeDiv == '0)) |=> !ovsTick);

  // R8: a load restarts the chain without a tick
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (!ovsTick && !bitTick && ovsCnt == '0));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic             busy,
  output logic [REG_W-1:0] divValue,
  output logic             ovsTick,
  output logic             bitTick
);
  logic [PRE_W-1:0] activePre;
  logic [DIV_W-1:0] activeDiv;
  logic             preWrap;
  baudStrobe_t      strobe;

  uart_baud_ctrl #(
    .RegW(REG_W), .PreW(PRE_W), .DivW(DIV_W), .PreLsb(PRE_LSB), .DivLsb(DIV_LSB)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .preWrap(preWrap),
    .activePre(activePre), .activeDiv(activeDiv), .busy(busy), .strobe(strobe)
  );

  uart_baud_datapath #(
    .PreW(PRE_W), .DivW(DIV_W), .Ovs(OVS)
  ) uDp (
    .clk(clk), .rstN(rstN), .activePre(activePre), .activeDiv(activeDiv),
    .strobe(strobe), .preWrap(preWrap), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  always_comb begin
    divValue = '0;
    divValue[PRE_LSB +: PRE_W] = activePre;
    divValue[DIV_LSB +: DIV_W] = activeDiv;
  end
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic        busy;
  logic [31:0] divValue;
  logic        ovsTick;
  logic        bitTick;

  int checks = 0;
  int fails  = 0;
  int curP   = 0;
  bit done   = 1'b0;

  uart_baud_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .busy(busy), .divValue(divValue), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  always #10 clk = ~clk;

  function automatic int expOvs(input int p, input int d);
    return (p + 1) * (d + 1);
  endfunction

  function automatic logic [31:0] expWord(input int p, input int d);
    logic [31:0] w = '0;
    w[19:16] = 4'(p);
    w[9:0]   = 10'(d);
    return w;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gapTo(input bit useBit, input int limit, output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!(useBit ? bitTick : ovsTick) && g < limit);
  endtask

  task automatic runSetting(input int p, input int d, input logic [31:0] noise,
                            input bit wantBit, input bit tryIgnore);
    logic [31:0] v;
    int n, k, firstOvs, firstBit, g, kOvs, lim;
    v = noise;
    v[19:16] = 4'(p);
    v[9:0]   = 10'(d);
    kOvs = expOvs(p, d);
    lim  = 13 * kOvs + 20;
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
    check("R5 busy after idle write", busy, 1);
    n = 0;
    if (tryIgnore) begin
      wrEn = 1'b1;
      wrData = ~v;
      @(negedge clk);
      wrEn = 1'b0;
      wrData = '0;
      n = 1;
    end
    while (busy && n <= 40) begin
      @(negedge clk);
      n++;
    end
    check("R6 busy clears within old prescale", (n >= 1 && n <= curP + 1), 1);
    if (tryIgnore) check("R7 write during busy ignored", divValue, expWord(p, d));
    else           check("R2 field readback", divValue, expWord(p, d));
    curP = p;
    k = 0; firstOvs = -1; firstBit = -1;
    while ((firstOvs < 0 || (wantBit && firstBit < 0)) && k < lim) begin
      @(negedge clk);
      k++;
      if (ovsTick && firstOvs < 0) firstOvs = k;
      if (bitTick && firstBit < 0) firstBit = k;
    end
    check("R8 first ovsTick after load", firstOvs, kOvs);
    if (wantBit) begin
      check("R8 first bitTick after load", firstBit, 13 * kOvs);
      gapTo(1'b1, lim, g);
      check("R4 bitTick period", g, 13 * kOvs);
    end
    gapTo(1'b0, lim, g);
    check("R3 ovsTick period", g, kOvs);
  endtask

  initial begin
    int unsigned seed;
    int g;
    seed = $urandom(32'h1b2d);
    rstN = 1'b0;
    wrEn = 1'b0;
    wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 divValue after reset", divValue, 0);
    check("R1 ovsTick every cycle", ovsTick, 1);
    @(negedge clk);
    check("R1 ovsTick every cycle", ovsTick, 1);
    gapTo(1'b1, 40, g);
    gapTo(1'b1, 40, g);
    check("R1 bitTick period 13", g, 13);

    runSetting(2, 5, 32'hFFF0_FC00, 1'b1, 1'b0);
    runSetting(11, 0, 32'h0000_0000, 1'b1, 1'b0);
    runSetting(3, 7, 32'hA5A5_5A5A, 1'b1, 1'b1);
    runSetting(0, 0, 32'h0000_0000, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      runSetting(int'($urandom_range(3, 0)), int'($urandom_range(40, 0)),
                 $urandom, 1'b1, (i % 3) == 1);
    end
    runSetting(15, 1023, 32'h0000_0000, 1'b0, 1'b0);
    runSetting(0, 1, 32'h0000_0000, 1'b1, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule